// File: doc/BRIEF.md
# Per-Dimension Quantising Sparse Encoder

This block turns a vector of fixed-point feature values into the binary input pattern used by a binary associative weight memory. Values arrive one dimension at a time through a valid/ready handshake. Each value is compared with a programmed ascending list of bin edges that belongs to its dimension. The bins may have unequal widths, so that each bin can hold roughly the same share of training samples. The result is a bin number.

The bin number is expanded into a short run of set bits. Runs for different bins never overlap, so the codes are mutually orthogonal. The code for each dimension is placed in that dimension's own slice of the full vector. For every accepted dimension the block also emits a global index, equal to dimension times bin count plus bin, for a controller that addresses weight rows by index. The edge values are chosen offline and written through a small write port. That port only acts while no vector is in progress.

The controller has three states. IDLE waits for dimension 0. COLLECT takes the remaining dimensions. FLUSH presents the finished vector for one cycle. The transitions are: IDLE to COLLECT when dimension 0 is accepted (or IDLE to FLUSH if there is only one dimension); COLLECT to FLUSH when the last dimension is accepted; FLUSH to IDLE unconditionally.

Top module: `quant_sparse_encoder`

## Requirements
- R1: After reset: in_ready is 1; busy, idx_valid and vec_valid are 0; every dimension's edge s (s = 0..BINS-2) holds (s+1)*2^VAL_W/BINS, which gives equal-width bins.
- R2: A write with cfg_we=1 while busy=0 stores cfg_data as edge cfg_slot of dimension cfg_dim. Edge s is the lowest value of bin s+1.
- R3: A value's bin is the number of edges of its dimension that are less than or equal to it. A value equal to an edge therefore lands in the upper bin, a value below edge 0 lands in bin 0, and a value at or above the last edge lands in bin BINS-1.
- R4: One value is taken on each cycle with in_valid and in_ready both high. Dimensions are taken in order 0..DIMS-1. In the next cycle idx_valid is 1 and idx_value = dim*BINS + bin; otherwise idx_valid is 0.
- R5: idx_last is 1 exactly with the index of dimension DIMS-1.
- R6: vec_valid is 1 for one cycle, in the same cycle as the last index. vec_data then has bit d*BINS*K + b*K + j set for each dimension d with bin b and each j < K, and every other bit clear, so exactly DIMS*K bits are set.
- R7: in_ready is 0 in the cycle that vec_valid is 1. busy is 1 from the first acceptance of a vector until the controller returns to IDLE.
- R8: Edge writes made while busy=1 are ignored.
- R9: Cycles with in_valid low hold the position within the vector; the next accepted value goes to the next dimension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Edge write strobe |
| cfg_dim | input | DIM_W | Dimension of the edge being written |
| cfg_slot | input | SLOT_W | Edge number within the dimension |
| cfg_data | input | VAL_W | Edge value |
| in_valid | input | 1 | Feature value is offered |
| in_ready | output | 1 | Encoder can take a value |
| in_value | input | VAL_W | Unsigned feature value |
| busy | output | 1 | A vector is in progress |
| idx_valid | output | 1 | Global index is valid |
| idx_value | output | IDX_W | dim*BINS + bin |
| idx_last | output | 1 | Index belongs to the last dimension |
| vec_valid | output | 1 | Full vector is ready |
| vec_data | output | DIMS*BINS*K | Concatenated sparse codes |

## Verification
Every value from 0 to 255 is driven into each dimension, first with the reset edges and then with unequal programmed edges. This tests the inclusive edge comparison: if the block used a strict comparison, every value equal to an edge would land one bin low, and both the index and the code slice would come out wrong. Full vectors are compared bit for bit. A design that misplaces a dimension's slice, or that keeps bits from the previous vector, would show extra or shifted bits. An edge write is issued in the middle of a vector, during a stall. The value sent next shows whether that write wrongly moved an edge, and the stall itself shows whether the dimension count skipped ahead or emitted a spurious index.

// File: rtl/qse_pkg.sv
package qse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FLUSH   = 2'd2
    } qse_state_t;
endpackage

// File: rtl/qse_edge_regs.sv
module qse_edge_regs #(
    parameter int DIMS   = 4,
    parameter int BINS   = 8,
    parameter int VAL_W  = 8,
    parameter int DIM_W  = 2,
    parameter int SLOT_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [DIM_W-1:0]                    wr_dim,
    input  logic [SLOT_W-1:0]                   wr_slot,
    input  logic [VAL_W-1:0]                    wr_data,
    output logic [DIMS*(BINS-1)*VAL_W-1:0]      edges_flat
);
    localparam int SLICE_W = (BINS-1)*VAL_W;

    for (genvar d = 0; d < DIMS; d++) begin : g_dim
        for (genvar s = 0; s < BINS-1; s++) begin : g_slot
            localparam longint unsigned RST_V = ((s + 1) * (64'd1 << VAL_W)) / BINS;
            logic [VAL_W-1:0] edge_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    edge_q <= VAL_W'(RST_V);
                else if (wr_en && (wr_dim == DIM_W'(d)) && (wr_slot == SLOT_W'(s)))
                    edge_q <= wr_data;
            end
            assign edges_flat[d*SLICE_W + s*VAL_W +: VAL_W] = edge_q;
        end
    end
endmodule

// File: rtl/qse_bin_finder.sv
module qse_bin_finder #(
    parameter int BINS  = 8,
    parameter int VAL_W = 8,
    parameter int BIN_W = 3
) (
    input  logic [VAL_W-1:0]            value,
    input  logic [(BINS-1)*VAL_W-1:0]   edges,
    output logic [BIN_W-1:0]            bin
);
    always_comb begin
        int cnt;
        cnt = 0;
        for (int s = 0; s < BINS-1; s++) begin
            if (edges[s*VAL_W +: VAL_W] <= value)
                cnt = cnt + 1;
        end
        bin = BIN_W'(cnt);
    end
endmodule

// File: rtl/qse_code_gen.sv
module qse_code_gen #(
    parameter int BINS  = 8,
    parameter int K     = 2,
    parameter int BIN_W = 3
) (
    input  logic [BIN_W-1:0]    bin,
    output logic [BINS*K-1:0]   code
);
    always_comb begin
        code = '0;
        for (int b = 0; b < BINS; b++) begin
            if (bin == BIN_W'(b))
                code[b*K +: K] = '1;
        end
    end
endmodule

// File: rtl/quant_sparse_encoder.sv
module quant_sparse_encoder #(
    parameter int DIMS   = 4,
    parameter int BINS   = 8,
    parameter int K      = 2,
    parameter int VAL_W  = 8,
    parameter int DIM_W  = (DIMS > 1) ? $clog2(DIMS) : 1,
    parameter int SLOT_W = (BINS > 2) ? $clog2(BINS-1) : 1,
    parameter int IDX_W  = $clog2(DIMS*BINS),
    parameter int VEC_W  = DIMS*BINS*K
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [DIM_W-1:0]     cfg_dim,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [VAL_W-1:0]     cfg_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [VAL_W-1:0]     in_value,
    output logic                 busy,
    output logic                 idx_valid,
    output logic [IDX_W-1:0]     idx_value,
    output logic                 idx_last,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_data
);
    import qse_pkg::*;

    localparam int BIN_W   = (BINS > 1) ? $clog2(BINS) : 1;
    localparam int SLICE_W = (BINS-1)*VAL_W;
    localparam int DCODE_W = BINS*K;

    qse_state_t state_q, state_d;
    logic [DIM_W-1:0]               dim_q;
    logic                           accept;
    logic                           last_dim;
    logic                           cfg_ok;
    logic [DIMS*SLICE_W-1:0]        edges_flat;
    logic [SLICE_W-1:0]             edges_sel;
    logic [BIN_W-1:0]               bin;
    logic [DCODE_W-1:0]             code;
    logic [VEC_W-1:0]               placed;

    assign accept   = in_valid && in_ready;
    assign last_dim = (dim_q == DIM_W'(DIMS-1));
    assign cfg_ok   = cfg_we && (state_q == ST_IDLE);

    qse_edge_regs #(
        .DIMS(DIMS), .BINS(BINS), .VAL_W(VAL_W), .DIM_W(DIM_W), .SLOT_W(SLOT_W)
    ) u_edges (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_ok), .wr_dim(cfg_dim),
        .wr_slot(cfg_slot), .wr_data(cfg_data), .edges_flat(edges_flat)
    );

    assign edges_sel = edges_flat[dim_q*SLICE_W +: SLICE_W];

    qse_bin_finder #(.BINS(BINS), .VAL_W(VAL_W), .BIN_W(BIN_W)) u_find (
        .value(in_value), .edges(edges_sel), .bin(bin)
    );

    qse_code_gen #(.BINS(BINS), .K(K), .BIN_W(BIN_W)) u_code (
        .bin(bin), .code(code)
    );

    always_comb begin
        placed = '0;
        placed[dim_q*DCODE_W +: DCODE_W] = code;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = last_dim ? ST_FLUSH : ST_COLLECT;
            ST_COLLECT: if (accept && last_dim) state_d = ST_FLUSH;
            ST_FLUSH:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        in_ready = 1'b1;
        busy     = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_COLLECT: ;
            ST_FLUSH:   in_ready = 1'b0;
            default:    begin in_ready = 1'b0; busy = 1'b0; end
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dim_q     <= '0;
            idx_valid <= 1'b0;
            idx_value <= '0;
            idx_last  <= 1'b0;
            vec_valid <= 1'b0;
            vec_data  <= '0;
        end else begin
            idx_valid <= accept;
            idx_last  <= accept && last_dim;
            vec_valid <= accept && last_dim;
            if (accept) begin
                idx_value <= IDX_W'(dim_q) * IDX_W'(BINS) + IDX_W'(bin);
                dim_q     <= last_dim ? '0 : dim_q + 1'b1;
                vec_data  <= (dim_q == '0) ? placed : (vec_data | placed);
            end
        end
    end
endmodule

// File: rtl/qse_checker.sv
module qse_checker #(
    parameter int DIMS  = 4,
    parameter int BINS  = 8,
    parameter int K     = 2,
    parameter int VEC_W = DIMS*BINS*K
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             busy,
    input logic             idx_valid,
    input logic             idx_last,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_data
);
    logic        acc;
    logic [15:0] seen_q;
    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else if (acc) seen_q <= (seen_q == 16'(DIMS-1)) ? '0 : seen_q + 16'd1;
    end

    assert_idx_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> idx_valid);
    assert_idx_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !idx_valid);
    assert_last_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seen_q == 16'(DIMS-1)) |=> idx_last);
    assert_vec_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && seen_q == 16'(DIMS-1)) |=> vec_valid);
    assert_vec_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($countones(vec_data) == DIMS*K));
    assert_flush_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !in_ready);
    assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);
endmodule

bind quant_sparse_encoder qse_checker #(
    .DIMS(DIMS), .BINS(BINS), .K(K), .VEC_W(VEC_W)
) u_qse_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .idx_valid(idx_valid), .idx_last(idx_last),
    .vec_valid(vec_valid), .vec_data(vec_data)
);

// File: tb/tb_quant_sparse_encoder.sv
module tb_quant_sparse_encoder;
    localparam int PERIOD = 10;
    localparam int DIMS = 4, BINS = 8, K = 2, VAL_W = 8;
    localparam int DIM_W = 2, SLOT_W = 3, IDX_W = 5, VEC_W = DIMS*BINS*K;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0;
    logic [DIM_W-1:0] cfg_dim = '0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [VAL_W-1:0] cfg_data = '0;
    logic in_valid = 0;
    logic [VAL_W-1:0] in_value = '0;
    logic in_ready, busy, idx_valid, idx_last, vec_valid;
    logic [IDX_W-1:0] idx_value;
    logic [VEC_W-1:0] vec_data;

    int tests = 0, fails = 0;
    bit done = 0;
    int edges [DIMS][BINS-1];
    int vals [DIMS];
    logic [VEC_W-1:0] exp_vec;

    always #(PERIOD/2) clk = ~clk;

    quant_sparse_encoder #(.DIMS(DIMS), .BINS(BINS), .K(K), .VAL_W(VAL_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dim(cfg_dim),
        .cfg_slot(cfg_slot), .cfg_data(cfg_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_value(in_value), .busy(busy),
        .idx_valid(idx_valid), .idx_value(idx_value), .idx_last(idx_last),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    task automatic check(input bit ok, input string req, input logic [VEC_W-1:0] act,
                         input logic [VEC_W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_bin(int d, int v);
        int c = 0;
        for (int s = 0; s < BINS-1; s++) if (edges[d][s] <= v) c++;
        return c;
    endfunction

    task automatic send_dim(int d);
        int b;
        in_valid = 1; in_value = VAL_W'(vals[d]);
        check(in_ready == 1, "R4 in_ready", VEC_W'(in_ready), 1);
        @(posedge clk); @(negedge clk);
        in_valid = 0;
        b = exp_bin(d, vals[d]);
        for (int j = 0; j < K; j++) exp_vec[d*BINS*K + b*K + j] = 1'b1;
        check(idx_valid == 1, "R4 idx_valid", VEC_W'(idx_valid), 1);
        check(idx_value == IDX_W'(d*BINS + b), "R3 idx_value", VEC_W'(idx_value),
              VEC_W'(d*BINS + b));
        check(idx_last == (d == DIMS-1), "R5 idx_last", VEC_W'(idx_last),
              VEC_W'(d == DIMS-1));
    endtask

    task automatic finish_vec();
        check(vec_valid == 1, "R6 vec_valid", VEC_W'(vec_valid), 1);
        check(vec_data == exp_vec, "R6 vec_data", vec_data, exp_vec);
        check(in_ready == 0, "R7 in_ready in flush", VEC_W'(in_ready), 0);
        @(posedge clk); @(negedge clk);
        check(vec_valid == 0 && busy == 0, "R7 back to idle", VEC_W'({vec_valid, busy}), 0);
    endtask

    task automatic send_vec();
        exp_vec = '0;
        for (int d = 0; d < DIMS; d++) send_dim(d);
        finish_vec();
    endtask

    task automatic write_edge(int d, int s, int v);
        cfg_we = 1; cfg_dim = DIM_W'(d); cfg_slot = SLOT_W'(s); cfg_data = VAL_W'(v);
        @(posedge clk); @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic sweep();
        for (int i = 0; i < 256; i++) begin
            for (int d = 0; d < DIMS; d++) vals[d] = (i + d*37) & 255;
            send_vec();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < DIMS; d++)
            for (int s = 0; s < BINS-1; s++) edges[d][s] = (s+1)*256/BINS;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        check(in_ready == 1 && busy == 0 && idx_valid == 0 && vec_valid == 0,
              "R1 reset outputs", VEC_W'({in_ready, busy, idx_valid, vec_valid}), VEC_W'(4'b1000));
        // R1 R3 uniform reset edges, all values
        sweep();
        // R2 program unequal edges while idle
        for (int d = 0; d < DIMS; d++)
            for (int s = 0; s < BINS-1; s++) begin
                edges[d][s] = 4*(s+1)*(s+1) + d;
                write_edge(d, s, edges[d][s]);
            end
        // R2 R3 sweep with programmed edges (equal-to-edge values included)
        sweep();
        // R8 R9: write during a stall mid-vector must be ignored
        exp_vec = '0;
        vals[0] = 100; vals[1] = 20; vals[2] = edges[2][3]; vals[3] = 255;
        send_dim(0);
        check(busy == 1, "R7 busy mid vector", VEC_W'(busy), 1);
        write_edge(1, 0, 250);
        check(idx_valid == 0, "R9 no index while stalled", VEC_W'(idx_valid), 0);
        repeat (2) @(negedge clk);
        check(idx_valid == 0 && busy == 1, "R9 stall holds", VEC_W'({idx_valid, busy}), 1);
        for (int d = 1; d < DIMS; d++) send_dim(d);  // R8: dim1 value 20 uses unchanged edges
        finish_vec();
        // R8 confirm again after idle
        exp_vec = '0;
        for (int d = 0; d < DIMS; d++) vals[d] = edges[d][0];
        send_vec();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule